// File: doc/BRIEF.md
# Per-Vector Scaled Integer Dot Product

This block computes a quantized dot product in which every short vector of integer elements carries its own scale. Each input beat holds one weight vector and one activation vector of `VEC_LEN` signed narrow integers. It also holds two unsigned scales, one that applies to the weight vector and one that applies to the activation vector. Because each scale covers only a short vector, the integer codes can stay narrow. Values far from the bulk of a vector may be clipped when the codes are produced upstream. Choosing the scales is outside this block.

For each accepted beat the unit forms the exact integer dot product of the two vectors. It multiplies that sum first by the weight scale and then by the activation scale, and adds the product into a wide signed accumulator. A beat flagged as last closes the dot product. The total is then presented on the result port for one cycle, and the accumulator starts again from zero for the next dot product. Beats may arrive back to back or with idle cycles between them. The pipeline has four register stages from input to result.

Top module: `vsq_dot_unit`

## Requirements
- R1: While reset is held and after it is released with no input, `out_valid` is 0 and `out_result` is 0.
- R2: A beat sampled with `in_valid` and `in_last` high produces `out_valid` exactly four rising edges later. `out_valid` stays low on the three edges in between when nothing else closes. The value is dot(w,a)·w_scale·a_scale plus any earlier beats of the same group.
- R3: A group of several beats yields the exact sum over its beats of dot(w,a)·w_scale·a_scale, for any number of beats and any scales.
- R4: After a result is emitted the accumulator is zero, so the next group's result contains none of the previous group's terms.
- R5: Elements are 4-bit two's complement values (-8..7). Lane i occupies bits [4i+3:4i] of `w_vec` and `a_vec`. Scales are unsigned 8-bit (0..255). The extremes all -8 by all -8 and all 7 by all -8 give the exact results 2048·ws·as and -1792·ws·as.
- R6: Cycles with `in_valid` low are ignored whatever the other inputs carry, including `in_last`. They do not change the accumulator and do not produce a result.
- R7: `out_valid` is high for one cycle per closing beat. `out_result` holds its last value while `out_valid` is low.
- R8: Two closing beats on consecutive cycles give two results on consecutive cycles, in input order.
- R9: A beat whose weight scale or activation scale is zero adds nothing to its group's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present on the data inputs |
| in_last | input | 1 | Beat is the final one of its dot product |
| w_vec | input | VEC_LEN*ELEM_W | Packed signed weight elements, lane 0 in the low bits |
| a_vec | input | VEC_LEN*ELEM_W | Packed signed activation elements, lane 0 in the low bits |
| w_scale | input | SCALE_W | Unsigned scale of this beat's weight vector |
| a_scale | input | SCALE_W | Unsigned scale of this beat's activation vector |
| out_valid | output | 1 | One-cycle strobe, result present |
| out_result | output | ACC_W | Signed scaled dot product of the closed group |

## Verification
Several properties are checked on every cycle. The result strobe must trace back to a closing beat four edges earlier. The result must stay still between strobes. The accumulator must be empty right after an emission and untouched on idle cycles. The per-vector integer sum must stay inside the range that 4-bit operands allow, and a zero scale must yield a zero term. The arithmetic values themselves can only be shown by the bench scenarios, which compare each result against an independently computed sum: random groups, signed extremes, zero scales, bubbles, group separation and back-to-back closes.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

  // Width of an exact signed sum of vec_len products of two signed elem_w values.
  function automatic int dot_sum_width(input int vec_len, input int elem_w);
    return 2 * elem_w + $clog2(vec_len);
  endfunction

  // Width of a signed value times an unsigned scale (scale widened by a sign bit).
  function automatic int scaled_width(input int val_w, input int scale_w);
    return val_w + scale_w + 1;
  endfunction

endpackage

// File: rtl/vsq_dot_stage.sv
module vsq_dot_stage #(
  parameter int VEC_LEN = 32,
  parameter int ELEM_W  = 4,
  parameter int SCALE_W = 8,
  localparam int SUM_W  = vsq_pkg::dot_sum_width(VEC_LEN, ELEM_W)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_last,
  input  logic [VEC_LEN*ELEM_W-1:0]   w_vec,
  input  logic [VEC_LEN*ELEM_W-1:0]   a_vec,
  input  logic [SCALE_W-1:0]          w_scale,
  input  logic [SCALE_W-1:0]          a_scale,
  output logic                        d_valid,
  output logic                        d_last,
  output logic signed [SUM_W-1:0]     d_sum,
  output logic [SCALE_W-1:0]          d_wsc,
  output logic [SCALE_W-1:0]          d_asc
);

  localparam int PROD_W = 2 * ELEM_W;
  localparam int HALF   = 2 ** (ELEM_W - 1);
  localparam int SUM_HI = VEC_LEN * HALF * HALF;
  localparam int SUM_LO = -(VEC_LEN * HALF * (HALF - 1));

  logic signed [SUM_W-1:0] lane_ext [VEC_LEN];
  logic signed [SUM_W-1:0] sum_c;

  for (genvar g = 0; g < VEC_LEN; g++) begin : g_lane
    logic signed [ELEM_W-1:0] we;
    logic signed [ELEM_W-1:0] ae;
    logic signed [PROD_W-1:0] wx;
    logic signed [PROD_W-1:0] ax;
    logic signed [PROD_W-1:0] pr;
    assign we = w_vec[g*ELEM_W +: ELEM_W];
    assign ae = a_vec[g*ELEM_W +: ELEM_W];
    assign wx = {{ELEM_W{we[ELEM_W-1]}}, we};
    assign ax = {{ELEM_W{ae[ELEM_W-1]}}, ae};
    assign pr = wx * ax;
    assign lane_ext[g] = {{(SUM_W-PROD_W){pr[PROD_W-1]}}, pr};
  end

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < VEC_LEN; i++) begin
      sum_c = sum_c + lane_ext[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_valid <= 1'b0;
      d_last  <= 1'b0;
      d_sum   <= '0;
      d_wsc   <= '0;
      d_asc   <= '0;
    end else begin
      d_valid <= in_valid;
      d_last  <= in_valid & in_last;
      if (in_valid) begin
        d_sum <= sum_c;
        d_wsc <= w_scale;
        d_asc <= a_scale;
      end
    end
  end

  AST_SUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    d_valid |-> (d_sum <= SUM_HI && d_sum >= SUM_LO)); // R5

endmodule

// File: rtl/vsq_rescale.sv
module vsq_rescale #(
  parameter int SUM_W   = 13,
  parameter int SCALE_W = 8,
  localparam int P1_W   = vsq_pkg::scaled_width(SUM_W, SCALE_W),
  localparam int P2_W   = vsq_pkg::scaled_width(P1_W, SCALE_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     d_valid,
  input  logic                     d_last,
  input  logic signed [SUM_W-1:0]  d_sum,
  input  logic [SCALE_W-1:0]       d_wsc,
  input  logic [SCALE_W-1:0]       d_asc,
  output logic                     t_valid,
  output logic                     t_last,
  output logic signed [P2_W-1:0]   t_term
);

  logic                    m_valid;
  logic                    m_last;
  logic signed [P1_W-1:0]  m_prod;
  logic [SCALE_W-1:0]      m_asc;

  // First multiply: integer sum times weight scale.
  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_last  <= 1'b0;
      m_prod  <= '0;
      m_asc   <= '0;
    end else begin
      m_valid <= d_valid;
      m_last  <= d_last;
      if (d_valid) begin
        m_prod <= d_sum * $signed({1'b0, d_wsc});
        m_asc  <= d_asc;
      end
    end
  end

  // Second multiply: weight-scaled sum times activation scale.
  always_ff @(posedge clk) begin
    if (rst) begin
      t_valid <= 1'b0;
      t_last  <= 1'b0;
      t_term  <= '0;
    end else begin
      t_valid <= m_valid;
      t_last  <= m_last;
      if (m_valid) begin
        t_term <= m_prod * $signed({1'b0, m_asc});
      end
    end
  end

  AST_ZERO_WSCALE: assert property (@(posedge clk) disable iff (rst)
    (d_valid && d_wsc == '0) |=> (m_prod == '0)); // R9

  AST_ZERO_ASCALE: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_asc == '0) |=> (t_term == '0)); // R9

endmodule

// File: rtl/vsq_accum.sv
module vsq_accum #(
  parameter int TERM_W = 31,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     t_valid,
  input  logic                     t_last,
  input  logic signed [TERM_W-1:0] t_term,
  output logic                     out_valid,
  output logic [ACC_W-1:0]         out_result
);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] term_ext;
  logic signed [ACC_W-1:0] sum_c;

  assign term_ext = {{(ACC_W-TERM_W){t_term[TERM_W-1]}}, t_term};
  assign sum_c    = acc_q + term_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= 1'b0;
      if (t_valid) begin
        if (t_last) begin
          out_result <= sum_c;
          out_valid  <= 1'b1;
          acc_q      <= '0;
        end else begin
          acc_q <= sum_c;
        end
      end
    end
  end

  AST_CLEAR_AFTER_EMIT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (acc_q == '0)); // R4

  AST_IDLE_NO_TOUCH: assert property (@(posedge clk) disable iff (rst)
    !t_valid |=> $stable(acc_q)); // R6

endmodule

// File: rtl/vsq_dot_unit.sv
module vsq_dot_unit #(
  parameter int VEC_LEN = 32,
  parameter int ELEM_W  = 4,
  parameter int SCALE_W = 8,
  parameter int ACC_W   = 40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_last,
  input  logic [VEC_LEN*ELEM_W-1:0] w_vec,
  input  logic [VEC_LEN*ELEM_W-1:0] a_vec,
  input  logic [SCALE_W-1:0]        w_scale,
  input  logic [SCALE_W-1:0]        a_scale,
  output logic                      out_valid,
  output logic [ACC_W-1:0]          out_result
);

  localparam int SUM_W = vsq_pkg::dot_sum_width(VEC_LEN, ELEM_W);
  localparam int P1_W  = vsq_pkg::scaled_width(SUM_W, SCALE_W);
  localparam int P2_W  = vsq_pkg::scaled_width(P1_W, SCALE_W);

  logic                    d_valid;
  logic                    d_last;
  logic signed [SUM_W-1:0] d_sum;
  logic [SCALE_W-1:0]      d_wsc;
  logic [SCALE_W-1:0]      d_asc;
  logic                    t_valid;
  logic                    t_last;
  logic signed [P2_W-1:0]  t_term;

  vsq_dot_stage #(
    .VEC_LEN (VEC_LEN),
    .ELEM_W  (ELEM_W),
    .SCALE_W (SCALE_W)
  ) u_dot (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .w_vec    (w_vec),
    .a_vec    (a_vec),
    .w_scale  (w_scale),
    .a_scale  (a_scale),
    .d_valid  (d_valid),
    .d_last   (d_last),
    .d_sum    (d_sum),
    .d_wsc    (d_wsc),
    .d_asc    (d_asc)
  );

  vsq_rescale #(
    .SUM_W   (SUM_W),
    .SCALE_W (SCALE_W)
  ) u_scale (
    .clk     (clk),
    .rst     (rst),
    .d_valid (d_valid),
    .d_last  (d_last),
    .d_sum   (d_sum),
    .d_wsc   (d_wsc),
    .d_asc   (d_asc),
    .t_valid (t_valid),
    .t_last  (t_last),
    .t_term  (t_term)
  );

  vsq_accum #(
    .TERM_W (P2_W),
    .ACC_W  (ACC_W)
  ) u_acc (
    .clk        (clk),
    .rst        (rst),
    .t_valid    (t_valid),
    .t_last     (t_last),
    .t_term     (t_term),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_last, 4)); // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_result)); // R7

endmodule

// File: tb/vsq_dot_unit_tb.sv
module vsq_dot_unit_tb;

  localparam int VL = 32;
  localparam int EW = 4;
  localparam int SW = 8;
  localparam int AW = 40;
  localparam int VW = VL * EW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_last = 1'b0;
  logic [VW-1:0] w_vec = '0;
  logic [VW-1:0] a_vec = '0;
  logic [SW-1:0] w_scale = '0;
  logic [SW-1:0] a_scale = '0;
  logic          out_valid;
  logic [AW-1:0] out_result;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  vsq_dot_unit #(.VEC_LEN(VL), .ELEM_W(EW), .SCALE_W(SW), .ACC_W(AW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .w_vec(w_vec), .a_vec(a_vec), .w_scale(w_scale), .a_scale(a_scale),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic longint term_ref(logic [VW-1:0] w, logic [VW-1:0] a,
                                      logic [SW-1:0] ws, logic [SW-1:0] as);
    longint s = 0;
    for (int i = 0; i < VL; i++) begin
      logic signed [EW-1:0] x;
      logic signed [EW-1:0] y;
      x = w[i*EW +: EW];
      y = a[i*EW +: EW];
      s += longint'(x) * longint'(y);
    end
    return s * longint'(ws) * longint'(as);
  endfunction

  function automatic logic [VW-1:0] fill(logic [EW-1:0] v);
    logic [VW-1:0] r;
    for (int i = 0; i < VL; i++) r[i*EW +: EW] = v;
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] r;
    for (int i = 0; i < VL; i++) r[i*EW +: EW] = EW'($urandom);
    return r;
  endfunction

  function automatic longint res();
    return longint'($signed(out_result));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [VW-1:0] w, logic [VW-1:0] a,
                      logic [SW-1:0] ws, logic [SW-1:0] as, bit last);
    in_valid = 1'b1;
    in_last  = last;
    w_vec    = w;
    a_vec    = a;
    w_scale  = ws;
    a_scale  = as;
    @(negedge clk);
  endtask

  // Idle beat with garbage data and in_last set; must be ignored.
  task automatic idle();
    in_valid = 1'b0;
    in_last  = 1'b1;
    w_vec    = rnd_vec();
    a_vec    = rnd_vec();
    w_scale  = SW'($urandom);
    a_scale  = SW'($urandom);
    @(negedge clk);
  endtask

  // Called on the negedge right after the closing beat was sampled.
  task automatic expect_out(longint exp, string req);
    for (int k = 0; k < 3; k++) begin
      check(out_valid == 1'b0, {req, " latency: early out_valid"}, out_valid, 0);
      idle();
    end
    check(out_valid == 1'b1, {req, " latency: out_valid on 4th edge"}, out_valid, 1);
    check(res() == exp, {req, " value"}, res(), exp);
    idle();
    check(out_valid == 1'b0, "R7 single-cycle strobe", out_valid, 0);
    check(res() == exp, "R7 result held", res(), exp);
  endtask

  task automatic t_reset_r1();
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(res() == 0, "R1 out_result in reset", res(), 0);
    rst = 1'b0;
    repeat (5) idle();
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(res() == 0, "R1 out_result after reset", res(), 0);
  endtask

  task automatic t_single_r2();
    for (int n = 0; n < 4; n++) begin
      logic [VW-1:0] w = rnd_vec();
      logic [VW-1:0] a = rnd_vec();
      logic [SW-1:0] ws = SW'($urandom);
      logic [SW-1:0] as = SW'($urandom);
      send(w, a, ws, as, 1'b1);
      expect_out(term_ref(w, a, ws, as), "R2");
    end
  endtask

  task automatic t_multi_r3();
    for (int g = 0; g < 20; g++) begin
      int nb = 1 + ($urandom % 5);
      longint exp = 0;
      for (int b = 0; b < nb; b++) begin
        logic [VW-1:0] w = rnd_vec();
        logic [VW-1:0] a = rnd_vec();
        logic [SW-1:0] ws = SW'($urandom);
        logic [SW-1:0] as = SW'($urandom);
        exp += term_ref(w, a, ws, as);
        send(w, a, ws, as, b == nb - 1);
      end
      expect_out(exp, "R3");
    end
  endtask

  task automatic t_clear_r4();
    logic [VW-1:0] w = rnd_vec();
    logic [VW-1:0] a = rnd_vec();
    send(fill(4'd7), fill(4'd7), 8'd200, 8'd200, 1'b0);
    send(fill(4'd7), fill(4'd7), 8'd200, 8'd200, 1'b1);
    expect_out(2 * longint'(32 * 49) * 40000, "R4 first group");
    send(w, a, 8'd3, 8'd5, 1'b1);
    expect_out(term_ref(w, a, 8'd3, 8'd5), "R4 next group starts from zero");
  endtask

  task automatic t_extremes_r5();
    send(fill(4'h8), fill(4'h8), 8'd255, 8'd255, 1'b1);
    expect_out(longint'(2048) * 255 * 255, "R5 all -8 by all -8");
    send(fill(4'h7), fill(4'h8), 8'd255, 8'd255, 1'b1);
    expect_out(longint'(-1792) * 255 * 255, "R5 all 7 by all -8");
    send(fill(4'hF), fill(4'h1), 8'd1, 8'd1, 1'b1);
    expect_out(-32, "R5 -1 by 1 unit scales");
  endtask

  task automatic t_bubble_r6();
    logic [VW-1:0] w1 = rnd_vec();
    logic [VW-1:0] a1 = rnd_vec();
    logic [VW-1:0] w2 = rnd_vec();
    logic [VW-1:0] a2 = rnd_vec();
    send(w1, a1, 8'd9, 8'd11, 1'b0);
    for (int k = 0; k < 6; k++) begin
      idle();
      check(out_valid == 1'b0, "R6 idle beat with in_last produced no result", out_valid, 0);
    end
    send(w2, a2, 8'd13, 8'd7, 1'b1);
    expect_out(term_ref(w1, a1, 8'd9, 8'd11) + term_ref(w2, a2, 8'd13, 8'd7),
               "R6 bubbles left accumulator unchanged");
  endtask

  task automatic t_b2b_r8();
    logic [VW-1:0] w1 = rnd_vec();
    logic [VW-1:0] a1 = rnd_vec();
    logic [VW-1:0] w2 = rnd_vec();
    logic [VW-1:0] a2 = rnd_vec();
    longint e1 = term_ref(w1, a1, 8'd17, 8'd19);
    longint e2 = term_ref(w2, a2, 8'd23, 8'd29);
    send(w1, a1, 8'd17, 8'd19, 1'b1);
    send(w2, a2, 8'd23, 8'd29, 1'b1);
    check(out_valid == 1'b0, "R8 early out_valid", out_valid, 0);
    idle();
    check(out_valid == 1'b0, "R8 early out_valid", out_valid, 0);
    idle();
    check(out_valid == 1'b1, "R8 first strobe", out_valid, 1);
    check(res() == e1, "R8 first result", res(), e1);
    idle();
    check(out_valid == 1'b1, "R8 second strobe", out_valid, 1);
    check(res() == e2, "R8 second result", res(), e2);
    idle();
    check(out_valid == 1'b0, "R8 strobe ends", out_valid, 0);
  endtask

  task automatic t_zero_scale_r9();
    logic [VW-1:0] w = rnd_vec();
    logic [VW-1:0] a = rnd_vec();
    send(fill(4'h8), fill(4'h8), 8'd0, 8'd255, 1'b0);
    send(fill(4'h7), fill(4'h7), 8'd255, 8'd0, 1'b0);
    send(w, a, 8'd2, 8'd3, 1'b1);
    expect_out(term_ref(w, a, 8'd2, 8'd3), "R9 zero-scale beats add nothing");
    send(fill(4'h8), fill(4'h8), 8'd0, 8'd0, 1'b1);
    expect_out(0, "R9 both scales zero");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_single_r2();
    t_multi_r3();
    t_clear_r4();
    t_extremes_r5();
    t_bubble_r6();
    t_b2b_r8();
    t_zero_scale_r9();
    repeat (3) idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule